// File: doc/BRIEF.md
# Parallel Frame Sync Code Correlator

This block looks for frame alignment in a serial time-division data stream. Bits arrive one per clock, qualified by `bit_en`, which marks the strobes of the recovered bit clock. The block keeps the last ten whole words of the stream in a sliding history. On every accepted bit it builds an 11-bit column from three sources: one bit out of each stored word, all taken at the same bit position, plus the bit on the input at that moment. It then compares this column against three stuff command patterns at the same time. The three patterns are negative stuff, positive stuff and no action.

The history shifts by one bit for each accepted input bit. As a result the sampled column moves across every bit position of the word frame. A match appears when the column holds the first bit of overhead words 1 to 11. When that happens, the block pulses `sync_found` to the sync controller that follows. It also reports which pattern matched and the bit offset at which the match was seen. The search then freezes until `rearm` signals a loss of frame sync.

Top module: `fs_code_correlator`

## Requirements
- R1: After reset, `sync_found` is 0, `code_idx` is 0, `match_offset` is 0, and the block is searching with an empty history count.
- R2: A bit on `din` is accepted only in a cycle with `bit_en`=1 and `rearm`=0. In any other cycle the value on `din` has no effect on the history, the counters or the outputs.
- R3: The column is ordered oldest first. Code bit 0 is compared with the bit accepted exactly 10 words (10×WORD_W bits) before the live bit, and code bit k with the bit accepted (10−k) words before it. Code bit 10 is compared with the live `din` bit itself, which is not stored first.
- R4: Three comparators run in parallel. `code_idx` reports which one matched: 0 for the negative stuff pattern (`CODE_NEG`), 1 for the positive stuff pattern (`CODE_POS`) and 2 for the no-action pattern (`CODE_NOACT`). The value 3 never appears.
- R5: `sync_found` is a single-cycle pulse. It is high in the cycle that follows the clock edge that accepted the matching live bit.
- R6: `match_offset` equals the zero-based index of the matching live bit, counted over the bits accepted since the last reset or rearm, taken modulo WORD_W. The search therefore finds a match at any bit position of the word.
- R7: No match is reported until 10×WORD_W bits have been accepted since the last reset or rearm. Stale history is never matched.
- R8: After a match the search is frozen. No further `sync_found` pulse occurs, and `code_idx` and `match_offset` keep their values until a later match.
- R9: `rearm`=1 restarts the search. It clears the lock, the history count and the bit position counter. A bit presented in a `rearm` cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `din`: one strobe per received bit |
| din | input | 1 | Serial data bit |
| rearm | input | 1 | Loss-of-sync indication; restarts the search |
| sync_found | output | 1 | One-cycle pulse on a pattern match |
| code_idx | output | 2 | Matched pattern: 0 negative, 1 positive, 2 no action |
| match_offset | output | $clog2(WORD_W) | Bit position of the match within the word |

## Verification
The bound checker watches several properties on every cycle:
- `sync_found` lasts exactly one cycle and follows an accepted bit.
- A match is never reported before the history has been refilled since the last rearm.
- No second pulse occurs without a rearm in between.
- The reported index and offset hold between matches and stay in range.

Some properties need a known stream and can only be shown by the bench scenarios:
- Which pattern matched, and whether the match fell at the right bit offset and bit number.
- That the oldest-first column ordering is correct.
- That disabled and rearm-cycle bits are dropped.

// File: rtl/fs_corr_pkg.sv
package fs_corr_pkg;
   localparam int unsigned N_CODES = 3;

   typedef enum logic [1:0] {
      SEL_NEG   = 2'd0,
      SEL_POS   = 2'd1,
      SEL_NOACT = 2'd2
   } code_sel_e;
endpackage

// File: rtl/fs_history.sv
module fs_history #(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned HIST_WORDS = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  shift_en,
   input  logic                  din,
   output logic [HIST_WORDS-1:0] column
);
   localparam int unsigned DEPTH = WORD_W * HIST_WORDS;

   logic [DEPTH-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q <= '0;
      else if (shift_en) hist_q <= {hist_q[DEPTH-2:0], din};
   end

   // column[0] is the oldest word, column[HIST_WORDS-1] the word just before the live bit
   for (genvar k = 0; k < HIST_WORDS; k++) begin : g_tap
      assign column[k] = hist_q[(HIST_WORDS - k) * WORD_W - 1];
   end
endmodule

// File: rtl/fs_code_cmp.sv
module fs_code_cmp #(
   parameter int unsigned           VEC_W = 11,
   parameter logic [VEC_W-1:0]      CODE  = '0
) (
   input  logic [VEC_W-1:0] vec,
   output logic             hit
);
   assign hit = (vec == CODE);
endmodule

// File: rtl/fs_search_ctrl.sv
module fs_search_ctrl
   import fs_corr_pkg::*;
#(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned HIST_WORDS = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic               rearm,
   input  logic [N_CODES-1:0] hits,
   output logic               shift_en,
   output logic               sync_found,
   output logic [1:0]         code_idx,
   output logic [$clog2(WORD_W)-1:0] match_offset
);
   localparam int unsigned OFS_W    = $clog2(WORD_W);
   localparam int unsigned FILL_MAX = WORD_W * HIST_WORDS;
   localparam int unsigned FILL_W   = $clog2(FILL_MAX + 1);

   logic [OFS_W-1:0]  pos_q;
   logic [FILL_W-1:0] fill_q;
   logic              locked_q;
   logic              accept, armed, fire;
   code_sel_e         enc;

   assign accept   = bit_en & ~rearm;
   assign shift_en = accept;
   assign armed    = ~locked_q & (fill_q == FILL_W'(FILL_MAX));
   assign fire     = accept & armed & (|hits);

   always_comb begin
      enc = SEL_NEG;
      for (int i = N_CODES - 1; i >= 0; i--) begin
         if (hits[i]) enc = code_sel_e'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q        <= '0;
         fill_q       <= '0;
         locked_q     <= 1'b0;
         sync_found   <= 1'b0;
         code_idx     <= 2'd0;
         match_offset <= '0;
      end else if (rearm) begin
         pos_q      <= '0;
         fill_q     <= '0;
         locked_q   <= 1'b0;
         sync_found <= 1'b0;
      end else begin
         sync_found <= fire;
         if (accept) begin
            pos_q <= (pos_q == OFS_W'(WORD_W - 1)) ? '0 : pos_q + 1'b1;
            if (fill_q != FILL_W'(FILL_MAX)) fill_q <= fill_q + 1'b1;
         end
         if (fire) begin
            locked_q     <= 1'b1;
            code_idx     <= enc;
            match_offset <= pos_q;
         end
      end
   end
endmodule

// File: rtl/fs_code_correlator.sv
module fs_code_correlator
   import fs_corr_pkg::*;
#(
   parameter int unsigned         WORD_W     = 8,
   parameter int unsigned         HIST_WORDS = 10,
   parameter logic [HIST_WORDS:0] CODE_NEG   = 11'b10110001011,
   parameter logic [HIST_WORDS:0] CODE_POS   = 11'b11001110101,
   parameter logic [HIST_WORDS:0] CODE_NOACT = 11'b10000111001
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bit_en,
   input  logic                      din,
   input  logic                      rearm,
   output logic                      sync_found,
   output logic [1:0]                code_idx,
   output logic [$clog2(WORD_W)-1:0] match_offset
);
   localparam int unsigned VEC_W = HIST_WORDS + 1;
   localparam logic [N_CODES-1:0][VEC_W-1:0] CODES = {CODE_NOACT, CODE_POS, CODE_NEG};

   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (HIST_WORDS < 1) begin : g_bad_depth
      $error("HIST_WORDS must be at least 1");
   end
   if (CODE_NEG == CODE_POS || CODE_NEG == CODE_NOACT || CODE_POS == CODE_NOACT) begin : g_bad_codes
      $error("stuff command codes must be distinct");
   end

   logic                  shift_en;
   logic [HIST_WORDS-1:0] column;
   logic [VEC_W-1:0]      vec;
   logic [N_CODES-1:0]    hits;

   fs_history #(.WORD_W(WORD_W), .HIST_WORDS(HIST_WORDS)) u_hist (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din), .column(column)
   );

   // live bit is the newest column entry and is used without storage
   assign vec = {din, column};

   for (genvar g = 0; g < N_CODES; g++) begin : g_cmp
      fs_code_cmp #(.VEC_W(VEC_W), .CODE(CODES[g])) u_cmp (
         .vec(vec), .hit(hits[g])
      );
   end

   fs_search_ctrl #(.WORD_W(WORD_W), .HIST_WORDS(HIST_WORDS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rearm(rearm), .hits(hits),
      .shift_en(shift_en), .sync_found(sync_found), .code_idx(code_idx),
      .match_offset(match_offset)
   );
endmodule

// File: rtl/fs_code_correlator_chk.sv
module fs_code_correlator_chk #(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned HIST_WORDS = 10
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bit_en,
   input logic                      rearm,
   input logic                      sync_found,
   input logic [1:0]                code_idx,
   input logic [$clog2(WORD_W)-1:0] match_offset
);
   localparam int unsigned FILL_MAX = WORD_W * HIST_WORDS;
   localparam int unsigned FILL_W   = $clog2(FILL_MAX + 1);

   logic [FILL_W-1:0] seen_q;
   logic              lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         lock_q <= 1'b0;
      end else if (rearm) begin
         seen_q <= '0;
         lock_q <= 1'b0;
      end else begin
         if (bit_en && seen_q != FILL_W'(FILL_MAX)) seen_q <= seen_q + 1'b1;
         if (sync_found) lock_q <= 1'b1;
      end
   end

   // R5
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |=> !sync_found);

   // R2
   found_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> $past(bit_en && !rearm));

   // R7
   fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> $past(seen_q) == FILL_W'(FILL_MAX));

   // R8
   single_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_found |-> !$past(lock_q));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_found |-> ($stable(code_idx) && $stable(match_offset)));

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_idx != 2'd3);

   // R6
   offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(match_offset) < WORD_W);
endmodule

bind fs_code_correlator fs_code_correlator_chk #(
   .WORD_W(WORD_W), .HIST_WORDS(HIST_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rearm(rearm),
   .sync_found(sync_found), .code_idx(code_idx), .match_offset(match_offset)
);

// File: tb/sim_fs_code_correlator.sv
module sim_fs_code_correlator;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 8;
   localparam int HW = 10;
   localparam logic [10:0] C_NEG   = 11'b10110001011;
   localparam logic [10:0] C_POS   = 11'b11001110101;
   localparam logic [10:0] C_NOACT = 11'b10000111001;
   // entry: {sel[10:9], preamble[8:1], gap[0]}
   localparam logic [10:0] CASES [6] = '{
      {2'd0, 8'd0,  1'b0}, {2'd1, 8'd3,  1'b0}, {2'd2, 8'd7,  1'b0},
      {2'd0, 8'd13, 1'b1}, {2'd1, 8'd5,  1'b1}, {2'd2, 8'd22, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, din = 1'b0, rearm = 1'b0;
   logic       sync_found;
   logic [1:0] code_idx;
   logic [2:0] match_offset;

   int tests = 0, fails = 0, pulses = 0, pulse_n = -1, cycles = 0;

   fs_code_correlator #(.WORD_W(W), .HIST_WORDS(HW), .CODE_NEG(C_NEG),
      .CODE_POS(C_POS), .CODE_NOACT(C_NOACT)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din), .rearm(rearm),
      .sync_found(sync_found), .code_idx(code_idx), .match_offset(match_offset)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [10:0] code_of(input int sel);
      return (sel == 0) ? C_NEG : (sel == 1) ? C_POS : C_NOACT;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive at a negedge, sample at the following negedge
   task automatic step(input logic en, input logic b, input logic ra, input int n);
      bit_en = en; din = b; rearm = ra;
      @(negedge clk);
      if (sync_found) begin pulses++; pulse_n = n; end
   endtask

   // column of code bits in bit 0 of words 1..11 after a preamble of p bits
   function automatic logic stream_bit(input int n, input int p, input logic [10:0] c);
      if (n >= p && (n - p) % W == 0 && (n - p) / W < 11) return c[(n - p) / W];
      return 1'b0;
   endfunction

   task automatic send(input int p, input int nbits, input logic [10:0] c, input logic gap);
      for (int n = 0; n < nbits; n++) begin
         logic b;
         b = stream_bit(n, p, c);
         step(1'b1, b, 1'b0, n);
         if (gap) step(1'b0, ~b, 1'b0, -2);
      end
   endtask

   // rearm cycle presents an enabled 1 bit that must be discarded (R9)
   task automatic do_rearm();
      step(1'b1, 1'b1, 1'b1, -3);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 sync_found", sync_found, 0);
      check("R1 code_idx", code_idx, 0);
      check("R1 match_offset", match_offset, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table: R3 R4 R5 R6 R9, gap entries cover R2
      for (int i = 0; i < 6; i++) begin
         int sel, p;
         logic gap;
         sel = int'(CASES[i][10:9]);
         p   = int'(CASES[i][8:1]);
         gap = CASES[i][0];
         do_rearm();
         pulses = 0; pulse_n = -1;
         send(p, p + 11 * W + W, code_of(sel), gap);
         check("R5 pulse count", pulses, 1);
         check("R3 match bit number", pulse_n, p + 10 * W);
         check("R4 code_idx", code_idx, sel);
         check("R6 match_offset", match_offset, p % W);
      end

      // R8 frozen: a different code without rearm gives nothing
      pulses = 0;
      send(2, 2 + 11 * W + W, C_NEG, 1'b0);
      check("R8 no pulse while locked", pulses, 0);
      check("R8 code_idx held", code_idx, 2);
      check("R8 offset held", match_offset, 22 % W);

      // R7 stale history: words 1..10 loaded, rearm, then live last bit
      do_rearm();
      send(0, 10 * W, C_POS, 1'b0);
      do_rearm();
      pulses = 0;
      step(1'b1, C_POS[10], 1'b0, 0);
      step(1'b0, 1'b0, 1'b0, -1);
      check("R7 no match on stale history", pulses, 0);
      check("R7 code_idx unchanged", code_idx, 2);

      // R2 disabled bits alone cannot complete a match
      do_rearm();
      pulses = 0;
      send(0, 10 * W, C_POS, 1'b0);
      step(1'b0, C_POS[10], 1'b0, -1);
      step(1'b0, C_POS[10], 1'b0, -1);
      check("R2 disabled bit ignored", pulses, 0);
      step(1'b1, C_POS[10], 1'b0, 10 * W);
      check("R2 enabled bit then matches", pulses, 1);
      check("R4 positive code index", code_idx, 1);
      check("R6 offset zero", match_offset, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule